// File: doc/BRIEF.md
# Two-Thread Capped Resource Allocator

This block is the allocation stage that sits between a two-thread micro-op queue and the out-of-order core. Every cycle it looks at the micro-op waiting at the head of each thread's queue. It decides which of the two threads, if either, may take entries in three shared tracking structures: the reorder buffer, the load buffer and the store buffer. It keeps an occupancy count per thread for each structure. Entries come back through per-thread release pulses when micro-ops retire or stores drain.

With two threads running, neither thread may hold more than half of any structure. This stops one thread from starving or deadlocking the other. When both threads can be served, the grant alternates from cycle to cycle. When only one thread can be served, that thread is granted every cycle. A thread whose micro-op does not fit is flagged as stalled, and the other thread keeps allocating in the same cycle. In single-thread mode the half caps are lifted, and a thread is limited only by the entries the two threads leave free between them.

Top module: `dual_thread_alloc`

## Requirements
- R1: After reset every occupancy count is zero and no grant is given while no micro-op is valid.
- R2: A micro-op of kind 2'b00 takes one reorder entry. Kind 2'b01 (load) also takes one load entry, and kind 2'b10 (store) also takes one store entry. All entries a micro-op needs are granted together, or none are.
- R3: With `single_mode` low, a thread is never granted a micro-op that would take its reorder, load or store count above ROB_N/2, LDB_N/2 or STB_N/2.
- R4: A valid micro-op whose needed entries do not fit raises that thread's `stall` in the same cycle and gets no grant. The other thread is still granted in that cycle when its micro-op fits.
- R5: When both threads have a fitting micro-op, the grant alternates between the threads every cycle, and thread 0 is favoured first after reset.
- R6: When only one thread has a fitting micro-op, that thread is granted every cycle.
- R7: With `single_mode` high, a thread is limited only by the sum of both threads' counts against the full size of each structure.
- R8: A grant shows on `grant` in the same cycle, and the occupancy outputs reflect it one cycle later. A release and a grant in the same cycle on the same count leave it unchanged.
- R9: A release pulse on a count that is already zero is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| single_mode | input | 1 | 1 lifts the per-thread half caps |
| uop_valid | input | 2 | Bit t: thread t has a micro-op waiting |
| uop_kind | input | 2x2 | Element t: kind of thread t's micro-op (00 plain, 01 load, 10 store) |
| rel_rob | input | 2 | Bit t: free one reorder entry of thread t |
| rel_ld | input | 2 | Bit t: free one load entry of thread t |
| rel_st | input | 2 | Bit t: free one store entry of thread t |
| grant | output | 2 | One-hot-or-zero: thread whose micro-op is accepted this cycle |
| stall | output | 2 | Bit t: thread t's valid micro-op does not fit |
| rob_occ | output | 2x$clog2(ROB_N+1) | Reorder entries held by each thread |
| ld_occ | output | 2x$clog2(LDB_N+1) | Load entries held by each thread |
| st_occ | output | 2x$clog2(STB_N+1) | Store entries held by each thread |

## Verification
The bench builds the block with a 12-entry reorder buffer, a 6-entry load buffer and a 4-entry store buffer, so the caps are 6, 3 and 2. Every cap and the full single-mode limit can then be reached within a dozen cycles. These small sizes make it cheap to drive one resource to its limit while the others still have room, which shows that a store stall does not block a following load. They also make it cheap to fill the whole reorder buffer from one thread in single mode and see the second thread stall on the shared total.

// File: rtl/alloc_pkg.sv
package alloc_pkg;

  typedef enum logic [1:0] {
    UOP_PLAIN = 2'b00,
    UOP_LOAD  = 2'b01,
    UOP_STORE = 2'b10,
    UOP_RSVD  = 2'b11
  } uop_kind_e;

  // One more entry fits for a thread holding `own` while the other holds `other`.
  function automatic logic has_room(input int unsigned own,
                                    input int unsigned other,
                                    input int unsigned cap,
                                    input int unsigned total,
                                    input logic        single);
    if (single) return (own + other) < total;
    return own < cap;
  endfunction

endpackage

// File: rtl/occ_counter.sv
module occ_counter #(
  parameter int unsigned N = 24,
  localparam int unsigned W = $clog2(N + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt
);

  logic dec_eff;
  assign dec_eff = dec && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + W'(inc) - W'(dec_eff);
  end

endmodule

// File: rtl/thread_pick.sv
module thread_pick (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fit,
  output logic [1:0] grant
);

  logic favour;  // thread that wins when both fit

  always_comb begin
    if (&fit) grant = favour ? 2'b10 : 2'b01;
    else      grant = fit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        favour <= 1'b0;
    else if (grant[0]) favour <= 1'b1;
    else if (grant[1]) favour <= 1'b0;
  end

endmodule

// File: rtl/dual_thread_alloc.sv
module dual_thread_alloc #(
  parameter int unsigned ROB_N = 126,
  parameter int unsigned LDB_N = 48,
  parameter int unsigned STB_N = 24
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 single_mode,
  input  logic [1:0]                           uop_valid,
  input  logic [1:0][1:0]                      uop_kind,
  input  logic [1:0]                           rel_rob,
  input  logic [1:0]                           rel_ld,
  input  logic [1:0]                           rel_st,
  output logic [1:0]                           grant,
  output logic [1:0]                           stall,
  output logic [1:0][$clog2(ROB_N+1)-1:0]      rob_occ,
  output logic [1:0][$clog2(LDB_N+1)-1:0]      ld_occ,
  output logic [1:0][$clog2(STB_N+1)-1:0]      st_occ
);
  import alloc_pkg::*;

  localparam int unsigned ROB_CAP = ROB_N / 2;
  localparam int unsigned LDB_CAP = LDB_N / 2;
  localparam int unsigned STB_CAP = STB_N / 2;

  // Named internal events for the checker
  logic [1:0] need_ld, need_st;
  logic [1:0] rob_ok, ld_ok, st_ok;
  logic [1:0] fit;

  for (genvar t = 0; t < 2; t++) begin : g_thr
    localparam int O = 1 - t;

    assign need_ld[t] = (uop_kind_e'(uop_kind[t]) == UOP_LOAD);
    assign need_st[t] = (uop_kind_e'(uop_kind[t]) == UOP_STORE);

    assign rob_ok[t] = has_room(32'(rob_occ[t]), 32'(rob_occ[O]), ROB_CAP, ROB_N, single_mode);
    assign ld_ok[t]  = has_room(32'(ld_occ[t]),  32'(ld_occ[O]),  LDB_CAP, LDB_N, single_mode);
    assign st_ok[t]  = has_room(32'(st_occ[t]),  32'(st_occ[O]),  STB_CAP, STB_N, single_mode);

    // All-or-nothing: every needed entry must fit
    assign fit[t]   = uop_valid[t] && rob_ok[t]
                      && (!need_ld[t] || ld_ok[t])
                      && (!need_st[t] || st_ok[t]);
    assign stall[t] = uop_valid[t] && !fit[t];

    occ_counter #(.N(ROB_N)) u_rob (
      .clk(clk), .rst_n(rst_n),
      .inc(grant[t]), .dec(rel_rob[t]), .cnt(rob_occ[t]));

    occ_counter #(.N(LDB_N)) u_ld (
      .clk(clk), .rst_n(rst_n),
      .inc(grant[t] && need_ld[t]), .dec(rel_ld[t]), .cnt(ld_occ[t]));

    occ_counter #(.N(STB_N)) u_st (
      .clk(clk), .rst_n(rst_n),
      .inc(grant[t] && need_st[t]), .dec(rel_st[t]), .cnt(st_occ[t]));
  end

  thread_pick u_pick (
    .clk(clk), .rst_n(rst_n), .fit(fit), .grant(grant));

endmodule

// File: rtl/alloc_checker.sv
module alloc_checker #(
  parameter int unsigned ROB_N = 126,
  parameter int unsigned LDB_N = 48,
  parameter int unsigned STB_N = 24
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            single_mode,
  input logic [1:0]                      uop_valid,
  input logic [1:0]                      rel_rob,
  input logic [1:0]                      grant,
  input logic [1:0]                      stall,
  input logic [1:0]                      fit,
  input logic [1:0][$clog2(ROB_N+1)-1:0] rob_occ,
  input logic [1:0][$clog2(LDB_N+1)-1:0] ld_occ,
  input logic [1:0][$clog2(STB_N+1)-1:0] st_occ
);

  localparam int unsigned ROB_CAP = ROB_N / 2;
  localparam int unsigned LDB_CAP = LDB_N / 2;
  localparam int unsigned STB_CAP = STB_N / 2;

  logic live;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  p_onehot_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_alternate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    live && (&fit) && $past(grant[0]) |-> grant[1]);

  p_rob_total_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rob_occ[0]) + int'(rob_occ[1])) <= int'(ROB_N));

  for (genvar t = 0; t < 2; t++) begin : g_chk
    localparam int O = 1 - t;

    p_stall_no_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stall[t] |-> !grant[t]);

    p_other_served_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stall[O] && uop_valid[t] && !stall[t] |-> grant[t]);

    p_lone_served_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fit[t] && !fit[O] |-> grant[t]);

    p_cap_rob_r3: assert property (@(posedge clk) disable iff (!rst_n)
      grant[t] && !single_mode |-> int'(rob_occ[t]) < int'(ROB_CAP));

    p_cap_ld_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !single_mode && live && $past(!single_mode) && (ld_occ[t] != $past(ld_occ[t]))
      |-> int'(ld_occ[t]) <= int'(LDB_CAP));

    p_cap_st_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !single_mode && live && $past(!single_mode) && (st_occ[t] != $past(st_occ[t]))
      |-> int'(st_occ[t]) <= int'(STB_CAP));

    p_rob_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      live |-> int'(rob_occ[t]) == int'($past(rob_occ[t])) + int'($past(grant[t]))
               - int'($past(rel_rob[t]) && ($past(rob_occ[t]) != '0)));
  end

endmodule

bind dual_thread_alloc alloc_checker #(
  .ROB_N(ROB_N), .LDB_N(LDB_N), .STB_N(STB_N)
) u_alloc_checker (
  .clk(clk), .rst_n(rst_n), .single_mode(single_mode),
  .uop_valid(uop_valid), .rel_rob(rel_rob),
  .grant(grant), .stall(stall), .fit(fit),
  .rob_occ(rob_occ), .ld_occ(ld_occ), .st_occ(st_occ)
);

// File: tb/test_dual_thread_alloc.sv
module test_dual_thread_alloc;

  localparam int unsigned ROB_N = 12;
  localparam int unsigned LDB_N = 6;
  localparam int unsigned STB_N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic single_mode = 1'b0;
  logic [1:0] uop_valid = '0;
  logic [1:0][1:0] uop_kind = '0;
  logic [1:0] rel_rob = '0, rel_ld = '0, rel_st = '0;
  logic [1:0] grant, stall;
  logic [1:0][$clog2(ROB_N+1)-1:0] rob_occ;
  logic [1:0][$clog2(LDB_N+1)-1:0] ld_occ;
  logic [1:0][$clog2(STB_N+1)-1:0] st_occ;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_thread_alloc #(.ROB_N(ROB_N), .LDB_N(LDB_N), .STB_N(STB_N)) i_dual_thread_alloc (
    .clk(clk), .rst_n(rst_n), .single_mode(single_mode),
    .uop_valid(uop_valid), .uop_kind(uop_kind),
    .rel_rob(rel_rob), .rel_ld(rel_ld), .rel_st(rel_st),
    .grant(grant), .stall(stall),
    .rob_occ(rob_occ), .ld_occ(ld_occ), .st_occ(st_occ));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle's inputs after the falling edge; outputs settle 1 ns later.
  task automatic put(input logic [1:0] v, input logic [1:0] k0, input logic [1:0] k1,
                     input logic [1:0] rr, input logic [1:0] rl, input logic [1:0] rs);
    @(negedge clk);
    uop_valid = v; uop_kind[0] = k0; uop_kind[1] = k1;
    rel_rob = rr; rel_ld = rl; rel_st = rs;
    #1;
  endtask

  task automatic idle();
    put(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
  endtask

  task automatic do_reset(input logic single);
    @(negedge clk);
    rst_n = 1'b0; single_mode = single;
    uop_valid = '0; rel_rob = '0; rel_ld = '0; rel_st = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    idle();
    chk("R1", "rob_occ0", int'(rob_occ[0]), 0);
    chk("R1", "st_occ1", int'(st_occ[1]), 0);
    chk("R1", "grant idle", int'(grant), 0);
  endtask

  task automatic t_alternate();
    do_reset(1'b0);
    for (int i = 0; i < 4; i++) begin
      put(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      chk("R5", "alternating grant", int'(grant), (i % 2 == 0) ? 1 : 2);
    end
    idle();
    chk("R8", "rob_occ0 after alternation", int'(rob_occ[0]), 2);
    chk("R8", "rob_occ1 after alternation", int'(rob_occ[1]), 2);
    for (int i = 0; i < 3; i++) begin
      put(2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      chk("R6", "lone thread1 grant", int'(grant), 2);
    end
    idle();
    chk("R6", "rob_occ1 lone", int'(rob_occ[1]), 5);
  endtask

  task automatic t_cap_stall();
    do_reset(1'b0);
    for (int i = 0; i < 6; i++) begin
      put(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      chk("R6", "thread0 below cap", int'(grant), 1);
    end
    put(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    chk("R3", "thread0 at rob cap stall", int'(stall), 1);
    chk("R4", "thread1 served past stall", int'(grant), 2);
    idle();
    chk("R3", "rob_occ0 held at cap", int'(rob_occ[0]), 6);
    chk("R4", "rob_occ1", int'(rob_occ[1]), 1);
  endtask

  task automatic t_kinds_release();
    do_reset(1'b0);
    put(2'b01, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
    put(2'b01, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
    chk("R2", "second store granted", int'(grant), 1);
    put(2'b01, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
    chk("R3", "store cap stall", int'(stall), 1);
    chk("R2", "no partial grant", int'(grant), 0);
    put(2'b01, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
    chk("R2", "load fits while stores full", int'(grant), 1);
    idle();
    chk("R2", "rob_occ0 atomic", int'(rob_occ[0]), 3);
    chk("R2", "st_occ0", int'(st_occ[0]), 2);
    chk("R2", "ld_occ0", int'(ld_occ[0]), 1);
    put(2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
    chk("R8", "grant with release", int'(grant), 1);
    idle();
    chk("R8", "grant plus release net zero", int'(rob_occ[0]), 3);
    put(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01);
    idle();
    chk("R8", "store release alone", int'(st_occ[0]), 1);
    put(2'b00, 2'b00, 2'b00, 2'b10, 2'b10, 2'b00);
    idle();
    chk("R9", "ld release at zero", int'(ld_occ[1]), 0);
    chk("R9", "rob release at zero", int'(rob_occ[1]), 0);
  endtask

  task automatic t_single();
    do_reset(1'b1);
    for (int i = 0; i < 12; i++) begin
      put(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
      chk("R7", "single mode past half cap", int'(grant), 1);
    end
    put(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    chk("R7", "both stall when total full", int'(stall), 3);
    chk("R7", "no grant when total full", int'(grant), 0);
    put(2'b00, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
    put(2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    chk("R7", "thread1 uses freed entry", int'(grant), 2);
    idle();
    chk("R7", "rob_occ0 single", int'(rob_occ[0]), 11);
    chk("R7", "rob_occ1 single", int'(rob_occ[1]), 1);
    single_mode = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    t_reset();
    t_alternate();
    t_cap_stall();
    t_kinds_release();
    t_single();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule